// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block sits between instruction decode and issue. It takes one decoded vector-prefixed instruction and turns it into a series of element operations, one per cycle. It behaves as a sub-program-counter: the element position is kept in a 32-bit architectural state word, so an exception can stop the loop between any two elements and the loop can continue later from where it stopped.

Source and destination positions advance separately. Each one skips the clear bits of its own predicate mask. A mask is taken either from an integer register value or from a bit vector built from condition-register fields, and each side chooses its origin on its own. In zeroing mode a masked-out destination element is not skipped: it is issued with a flag that tells the execution stage to write zero. For every element the block gives issue the operand register numbers (base plus position for vector operands, base alone for scalar ones) and a flag that marks a source register number equal to zero.

The state word is loaded and read through a register-access port. The same port reaches the save copy that holds the state word across an exception.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset the state word and the save word both read 0, `busy_o` is low and no element is issued.
- R2: With `spr_we_i` high, `spr_sel_i`=0 writes the state word and `spr_sel_i`=1 writes the save word. Bits 31:28 are always stored as 0. The state word layout is MVL in [6:0], VL in [13:7], source step in [20:14] and destination step in [27:21].
- R3: An `instr_valid_i` accepted while VL is 0 raises `done_o` in that same cycle and issues no element.
- R4: With no predication (`pmode_i`=0), elements 0 to VL-1 are issued in order, one in each non-stalled cycle, starting the cycle after the instruction is accepted. A vector operand register is (base + index) modulo 128. A scalar operand register is its base.
- R5: In twin mode (`pmode_i`=2) without zeroing, the source index is the lowest set bit of mask A at or above the source step, and the destination index is the lowest set bit of mask B at or above the destination step. After each element, each step moves to one past the index it used.
- R6: In single mode (`pmode_i`=1), mask A governs both the source side and the destination side.
- R7: `sel_cr_a_i` and `sel_cr_b_i` each choose the CR-derived mask (1) or the integer mask (0) for their own side. The unused mask has no effect.
- R8: With zeroing, every destination position from the step up to VL-1 is issued. A position whose mask-B bit is clear is issued with `issue_zero_o`=1. In twin mode, a position that finds no remaining source bit is also issued with the flag, and the source step does not move. In single mode the source position follows the destination position.
- R9: Without zeroing, when either mask has no set bit left below VL, the instruction completes with no further element.
- R10: `done_o` is raised in the cycle of the last element. Both steps then return to 0, while VL and MVL are kept.
- R11: While `stall_i` is high, no element is issued and the state word holds.
- R12: An `exc_i` cycle issues nothing. In the next cycle `save_stb_o` is high, `save_o` equals the state word of the `exc_i` cycle, and `busy_o` is low.
- R13: `restore_i` copies the save word into the state word. Accepting the instruction again then continues from the restored steps.
- R14: `issue_src_r0_o` is 1 only when all 7 bits of the issued source register number are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Decoded vector instruction offered |
| src_base_i | input | 7 | Source operand base register |
| src_vec_i | input | 1 | Source operand is a vector |
| dst_base_i | input | 7 | Destination operand base register |
| dst_vec_i | input | 1 | Destination operand is a vector |
| pmode_i | input | 2 | 0 none, 1 single, 2 twin, 3 as none |
| zeroing_i | input | 1 | Zeroing mode |
| sel_cr_a_i | input | 1 | Mask A origin: 1 CR-derived, 0 integer |
| sel_cr_b_i | input | 1 | Mask B origin: 1 CR-derived, 0 integer |
| int_mask_a_i | input | NELEM | Integer predicate, side A |
| cr_mask_a_i | input | NELEM | CR-derived predicate, side A |
| int_mask_b_i | input | NELEM | Integer predicate, side B |
| cr_mask_b_i | input | NELEM | CR-derived predicate, side B |
| stall_i | input | 1 | Hold the current element |
| exc_i | input | 1 | Exception: freeze and save |
| restore_i | input | 1 | Reload state from the save word |
| spr_we_i | input | 1 | Register write strobe |
| spr_sel_i | input | 1 | 0 state word, 1 save word |
| spr_wdata_i | input | 32 | Register write data |
| busy_o | output | 1 | Element loop active |
| issue_valid_o | output | 1 | Element issued this cycle |
| issue_src_o | output | 7 | Source register number |
| issue_dst_o | output | 7 | Destination register number |
| issue_zero_o | output | 1 | Write zero to destination |
| issue_src_r0_o | output | 1 | Source register number is 0 |
| done_o | output | 1 | Instruction retires |
| save_stb_o | output | 1 | State saved this cycle |
| state_o | output | 32 | State word |
| save_o | output | 32 | Save word |

## Verification
The sequencer is driven with several patterns, and each pattern separates one failure mode from the rest. Full masks with a vector source and a scalar destination show whether the indices and the register offsets are right. Sparse twin masks that differ between the sides show whether the two steps are truly independent. A single-mode mask taken from the CR input, with different junk on the integer input, shows whether the mask origin is selected correctly. Zeroing runs in both single and twin mode show whether a clear position is flagged rather than skipped. Masks with no bit below VL, VL of zero, a stall in the middle of a loop, and an exception followed by a restore each test one way the loop can stop or resume. A base of 64 tells a full 7-bit zero compare apart from a 5-bit one.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int REG_W  = 7;
    localparam int STEP_W = 7;
    localparam int SPR_W  = 32;

    typedef enum logic [1:0] {
        PM_NONE   = 2'd0,
        PM_SINGLE = 2'd1,
        PM_TWIN   = 2'd2,
        PM_RSVD   = 2'd3
    } pmode_e;

    // state word: reserved | dststep | srcstep | vl | mvl (LSB)
    typedef struct packed {
        logic [3:0]        rsvd;
        logic [STEP_W-1:0] dststep;
        logic [STEP_W-1:0] srcstep;
        logic [STEP_W-1:0] vl;
        logic [STEP_W-1:0] mvl;
    } vstate_t;

endpackage

// File: rtl/vseq_scan.sv
// Finds the lowest set mask bit at or above a start index and below a limit.
module vseq_scan #(
    parameter int N  = 64,
    parameter int SW = 7
) (
    input  logic [N-1:0]  mask_i,
    input  logic [SW-1:0] from_i,
    input  logic [SW-1:0] limit_i,
    output logic          found_o,
    output logic [SW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i] && (i >= int'(from_i)) && (i < int'(limit_i))) begin
                found_o = 1'b1;
                idx_o   = SW'(i);
            end
        end
    end
endmodule

// File: rtl/vseq_regmap.sv
// Element register number: base plus step for vector operands.
module vseq_regmap #(
    parameter int RW = 7
) (
    input  logic [RW-1:0] base_i,
    input  logic          vec_i,
    input  logic [RW-1:0] step_i,
    output logic [RW-1:0] reg_o
);
    always_comb reg_o = vec_i ? (base_i + step_i) : base_i;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int NELEM = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid_i,
    input  logic [REG_W-1:0] src_base_i,
    input  logic             src_vec_i,
    input  logic [REG_W-1:0] dst_base_i,
    input  logic             dst_vec_i,
    input  logic [1:0]       pmode_i,
    input  logic             zeroing_i,
    input  logic             sel_cr_a_i,
    input  logic             sel_cr_b_i,
    input  logic [NELEM-1:0] int_mask_a_i,
    input  logic [NELEM-1:0] cr_mask_a_i,
    input  logic [NELEM-1:0] int_mask_b_i,
    input  logic [NELEM-1:0] cr_mask_b_i,
    input  logic             stall_i,
    input  logic             exc_i,
    input  logic             restore_i,
    input  logic             spr_we_i,
    input  logic             spr_sel_i,
    input  logic [SPR_W-1:0] spr_wdata_i,
    output logic             busy_o,
    output logic             issue_valid_o,
    output logic [REG_W-1:0] issue_src_o,
    output logic [REG_W-1:0] issue_dst_o,
    output logic             issue_zero_o,
    output logic             issue_src_r0_o,
    output logic             done_o,
    output logic             save_stb_o,
    output logic [SPR_W-1:0] state_o,
    output logic [SPR_W-1:0] save_o
);
    localparam int SW = STEP_W;
    localparam int IW = $clog2(NELEM);
    localparam logic [SPR_W-1:0] WMASK = {4'b0, {(SPR_W-4){1'b1}}};

    typedef struct packed {
        logic [REG_W-1:0] sbase;
        logic             svec;
        logic [REG_W-1:0] dbase;
        logic             dvec;
        pmode_e           mode;
        logic             zero;
        logic [NELEM-1:0] ma;
        logic [NELEM-1:0] mb;
    } instr_t;

    typedef struct packed {
        vstate_t st;
        vstate_t sv;
        logic    run;
        logic    stb;
        instr_t  cur;
    } seq_t;

    seq_t seq_d, seq_q;

    // ---------------- mask selection at acceptance ----------------
    logic [NELEM-1:0] raw_a, raw_b, eff_a, eff_b;
    pmode_e           mode_in;

    always_comb begin
        mode_in = pmode_e'(pmode_i);
        raw_a   = sel_cr_a_i ? cr_mask_a_i : int_mask_a_i;
        raw_b   = sel_cr_b_i ? cr_mask_b_i : int_mask_b_i;
        case (mode_in)
            PM_SINGLE: begin eff_a = raw_a; eff_b = raw_a; end
            PM_TWIN:   begin eff_a = raw_a; eff_b = raw_b; end
            default:   begin eff_a = '1;    eff_b = '1;    end
        endcase
    end

    // ---------------- per-side scan and register mapping ----------------
    logic [NELEM-1:0] side_mask  [2];
    logic [SW-1:0]    side_from  [2];
    logic             side_found [2];
    logic [SW-1:0]    side_idx   [2];
    logic [REG_W-1:0] side_base  [2];
    logic             side_vec   [2];
    logic [SW-1:0]    side_pick  [2];
    logic [REG_W-1:0] side_reg   [2];

    always_comb begin
        side_mask[0] = seq_q.cur.ma;
        side_mask[1] = seq_q.cur.mb;
        side_from[0] = seq_q.st.srcstep;
        side_from[1] = seq_q.st.dststep;
        side_base[0] = seq_q.cur.sbase;
        side_base[1] = seq_q.cur.dbase;
        side_vec[0]  = seq_q.cur.svec;
        side_vec[1]  = seq_q.cur.dvec;
    end

    for (genvar k = 0; k < 2; k++) begin : g_side
        vseq_scan #(.N(NELEM), .SW(SW)) u_scan (
            .mask_i  (side_mask[k]),
            .from_i  (side_from[k]),
            .limit_i (seq_q.st.vl),
            .found_o (side_found[k]),
            .idx_o   (side_idx[k])
        );
        vseq_regmap #(.RW(REG_W)) u_map (
            .base_i (side_base[k]),
            .vec_i  (side_vec[k]),
            .step_i (side_pick[k]),
            .reg_o  (side_reg[k])
        );
    end

    // ---------------- element choice ----------------
    logic          dbit, el_ok, el_zero, fin;
    logic [SW-1:0] s_sel, d_sel, nsrc, ndst;

    always_comb begin
        dbit = 1'b0;
        if (int'(seq_q.st.dststep) < NELEM)
            dbit = seq_q.cur.mb[seq_q.st.dststep[IW-1:0]];
        if (!seq_q.cur.zero) begin
            el_ok   = side_found[0] && side_found[1];
            el_zero = 1'b0;
            s_sel   = side_idx[0];
            d_sel   = side_idx[1];
            nsrc    = side_idx[0] + SW'(1);
            ndst    = side_idx[1] + SW'(1);
            fin     = !el_ok || (nsrc >= seq_q.st.vl) || (ndst >= seq_q.st.vl);
        end else begin
            el_ok = 1'b1;
            d_sel = seq_q.st.dststep;
            ndst  = seq_q.st.dststep + SW'(1);
            fin   = ndst >= seq_q.st.vl;
            if (seq_q.cur.mode == PM_SINGLE) begin
                s_sel   = seq_q.st.dststep;
                nsrc    = seq_q.st.dststep + SW'(1);
                el_zero = !dbit;
            end else if (dbit && side_found[0]) begin
                s_sel   = side_idx[0];
                nsrc    = side_idx[0] + SW'(1);
                el_zero = 1'b0;
            end else begin
                s_sel   = seq_q.st.srcstep;
                nsrc    = seq_q.st.srcstep;
                el_zero = 1'b1;
            end
        end
        side_pick[0] = s_sel;
        side_pick[1] = d_sel;
    end

    // ---------------- control ----------------
    logic quiet, start, adv;
    always_comb begin
        quiet = !exc_i && !restore_i && !spr_we_i;
        start = quiet && !seq_q.run && instr_valid_i;
        adv   = quiet && seq_q.run && !stall_i;
    end

    always_comb begin
        seq_d     = seq_q;
        seq_d.stb = 1'b0;
        if (exc_i) begin
            seq_d.sv  = seq_q.st;
            seq_d.stb = 1'b1;
            seq_d.run = 1'b0;
        end else if (restore_i) begin
            seq_d.st  = seq_q.sv;
            seq_d.run = 1'b0;
        end else if (spr_we_i) begin
            if (spr_sel_i) seq_d.sv = vstate_t'(spr_wdata_i & WMASK);
            else           seq_d.st = vstate_t'(spr_wdata_i & WMASK);
            seq_d.run = 1'b0;
        end else if (start) begin
            seq_d.cur.sbase = src_base_i;
            seq_d.cur.svec  = src_vec_i;
            seq_d.cur.dbase = dst_base_i;
            seq_d.cur.dvec  = dst_vec_i;
            seq_d.cur.mode  = mode_in;
            seq_d.cur.zero  = zeroing_i;
            seq_d.cur.ma    = eff_a;
            seq_d.cur.mb    = eff_b;
            seq_d.run       = seq_q.st.vl != '0;
        end else if (adv) begin
            if (fin) begin
                seq_d.st.srcstep = '0;
                seq_d.st.dststep = '0;
                seq_d.run        = 1'b0;
            end else begin
                seq_d.st.srcstep = nsrc;
                seq_d.st.dststep = ndst;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy_o         = seq_q.run;
        issue_valid_o  = adv && el_ok;
        issue_src_o    = side_reg[0];
        issue_dst_o    = side_reg[1];
        issue_zero_o   = adv && el_ok && el_zero;
        issue_src_r0_o = side_reg[0] == '0;
        done_o         = (start && (seq_q.st.vl == '0)) || (adv && fin);
        save_stb_o     = seq_q.stb;
        state_o        = seq_q.st;
        save_o         = seq_q.sv;
    end

    // ---------------- assertions ----------------
    // R3
    vl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && seq_q.st.vl == '0) |-> (done_o && !issue_valid_o));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && stall_i && quiet) |=> (busy_o && $stable(state_o)));

    // R11
    no_issue_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> !stall_i);

    // R12
    exc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> (save_stb_o && save_o == $past(state_o) && !busy_o));

    // R10
    done_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && busy_o) |=> (!busy_o && state_o[27:14] == '0));

    // R8
    zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_zero_o |-> (issue_valid_o && seq_q.cur.zero));

endmodule

// File: tb/sim_vec_elem_seq.sv
module sim_vec_elem_seq;
    import vseq_pkg::*;
    localparam int N = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic instr_valid = 0, src_vec = 0, dst_vec = 0, zeroing = 0;
    logic [6:0] src_base = 0, dst_base = 0;
    logic [1:0] pmode = 0;
    logic sel_a = 0, sel_b = 0, stall = 0, exc = 0, restore = 0, spr_we = 0, spr_sel = 0;
    logic [N-1:0] ima = 0, cma = 0, imb = 0, cmb = 0;
    logic [31:0] spr_wdata = 0;
    logic busy, iv, izero, ir0, done, sstb;
    logic [6:0] isrc, idst;
    logic [31:0] state, save;

    always #5 clk = ~clk;

    vec_elem_seq #(.NELEM(N)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid),
        .src_base_i(src_base), .src_vec_i(src_vec), .dst_base_i(dst_base), .dst_vec_i(dst_vec),
        .pmode_i(pmode), .zeroing_i(zeroing), .sel_cr_a_i(sel_a), .sel_cr_b_i(sel_b),
        .int_mask_a_i(ima), .cr_mask_a_i(cma), .int_mask_b_i(imb), .cr_mask_b_i(cmb),
        .stall_i(stall), .exc_i(exc), .restore_i(restore), .spr_we_i(spr_we),
        .spr_sel_i(spr_sel), .spr_wdata_i(spr_wdata), .busy_o(busy), .issue_valid_o(iv),
        .issue_src_o(isrc), .issue_dst_o(idst), .issue_zero_o(izero), .issue_src_r0_o(ir0),
        .done_o(done), .save_stb_o(sstb), .state_o(state), .save_o(save));

    int n_chk = 0, n_err = 0, n_iss = 0, n_done = 0;
    string req = "R4";
    logic [15:0] exp_q[$];

    task automatic check(input bit ok, input string r, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // monitor: pops expected elements as the design issues them
    always begin
        @(negedge clk);
        #4;
        if (rst_n) begin
            if (iv) begin
                logic [15:0] got;
                got = {ir0, izero, isrc, idst};
                n_iss++;
                if (exp_q.size() == 0) check(1'b0, req, "unexpected element", 32'(got), 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(got == e, req, "element {r0,zero,src,dst}", 32'(got), 32'(e));
                end
            end
            if (done) n_done++;
        end
    end

    function automatic int first_set(input logic [N-1:0] m, input int from, input int vl);
        for (int i = from; i < vl && i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic push_el(input int si, input int di, input bit z, input int sb, input bit sv,
                           input int db, input bit dv);
        int s, d;
        s = sv ? (sb + si) % 128 : sb;
        d = dv ? (db + di) % 128 : db;
        exp_q.push_back({(s == 0), z, 7'(s), 7'(d)});
    endtask

    // reference: expected element list from the requirements
    task automatic model(input int vl, input int ss, input int ds, input int mode, input bit zf,
                         input logic [N-1:0] ma, input logic [N-1:0] mb,
                         input int sb, input bit sv, input int db, input bit dv);
        int s, d, fs, fd;
        s = ss; d = ds;
        if (zf) begin
            while (d < vl) begin
                if (mode == 1) begin
                    push_el(d, d, !mb[d], sb, sv, db, dv);
                    s = d + 1;
                end else begin
                    fs = first_set(ma, s, vl);
                    if (mb[d] && fs >= 0) begin push_el(fs, d, 0, sb, sv, db, dv); s = fs + 1; end
                    else push_el(s, d, 1, sb, sv, db, dv);
                end
                d++;
            end
        end else begin
            forever begin
                fs = first_set(ma, s, vl);
                fd = first_set(mb, d, vl);
                if (fs < 0 || fd < 0) break;
                push_el(fs, fd, 0, sb, sv, db, dv);
                s = fs + 1; d = fd + 1;
                if (s >= vl || d >= vl) break;
            end
        end
    endtask

    task automatic spr_write(input bit sel, input logic [31:0] v);
        @(negedge clk);
        spr_we = 1; spr_sel = sel; spr_wdata = v;
        @(negedge clk);
        spr_we = 0;
    endtask

    task automatic setvl(input int vl, input int ss, input int ds);
        spr_write(0, {4'b0, 7'(ds), 7'(ss), 7'(vl), 7'd64});
    endtask

    // drive one instruction, push its model, wait for retirement
    task automatic run(input string r, input int vl, input int mode, input bit zf,
                       input bit ca, input bit cb, input logic [N-1:0] ia, input logic [N-1:0] cav,
                       input logic [N-1:0] ib, input logic [N-1:0] cbv,
                       input int sb, input bit sv, input int db, input bit dv);
        logic [N-1:0] ra, rb, ea, eb;
        int pd, pi;
        req = r;
        setvl(vl, 0, 0);
        ra = ca ? cav : ia; rb = cb ? cbv : ib;
        if (mode == 1) begin ea = ra; eb = ra; end
        else if (mode == 2) begin ea = ra; eb = rb; end
        else begin ea = '1; eb = '1; end
        model(vl, 0, 0, mode, zf, ea, eb, sb, sv, db, dv);
        pd = n_done; pi = n_iss;
        @(negedge clk);
        src_base = 7'(sb); src_vec = sv; dst_base = 7'(db); dst_vec = dv;
        pmode = 2'(mode); zeroing = zf; sel_a = ca; sel_b = cb;
        ima = ia; cma = cav; imb = ib; cmb = cbv; instr_valid = 1;
        @(negedge clk);
        instr_valid = 0;
        while (n_done == pd) @(negedge clk);
        check(exp_q.size() == 0, r, "elements left unissued", exp_q.size(), 0);
        // R10: steps back to zero, VL kept
        check(state[27:14] == 0 && state[13:7] == 7'(vl), "R10", "state after done",
              state, {4'b0, 14'b0, 7'(vl), 7'd64});
        exp_q.delete();
        if (vl == 0) check(n_iss == pi, "R3", "issues with VL=0", n_iss - pi, 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check(state == 0 && save == 0, "R1", "reset words", state | save, 0);
        check(!busy && !iv, "R1", "reset busy/issue", {busy, iv}, 0);

        // R2: reserved bits dropped, sel chooses the word
        spr_write(1, 32'hFFFF_FFFF);
        check(save == 32'h0FFF_FFFF, "R2", "save word write", save, 32'h0FFF_FFFF);
        spr_write(0, 32'h1234_5678);
        check(state == 32'h0234_5678, "R2", "state word write", state, 32'h0234_5678);

        // R4: no predication, vector src, scalar dst
        run("R4", 5, 0, 0, 0, 0, 0, 0, 0, 0, 10, 1, 3, 0);
        // R4: wrap of vector register number
        run("R4", 4, 0, 0, 0, 0, 0, 0, 0, 0, 126, 1, 20, 1);
        // R3: VL zero
        run("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 2, 1);
        // R5: twin, independent skipping
        run("R5", 8, 2, 0, 0, 0, 64'hB2, 64'h0, 64'h69, 64'h0, 8, 1, 40, 1);
        // R6 / R7: single mode, CR mask chosen, integer mask junk
        run("R7", 8, 1, 0, 1, 0, 64'hFF, 64'h5A, 64'h0, 64'h0, 16, 1, 32, 1);
        // R7: twin with CR on side B only
        run("R7", 6, 2, 0, 0, 1, 64'h2D, 64'h0, 64'h3F, 64'h36, 2, 1, 50, 1);
        // R8: zeroing, twin (source runs out)
        run("R8", 8, 2, 1, 0, 0, 64'h05, 64'h0, 64'hD3, 64'h0, 4, 1, 60, 1);
        // R8: zeroing, single
        run("R8", 6, 1, 1, 0, 0, 64'h29, 64'h0, 64'h0, 64'h0, 8, 1, 24, 1);
        // R9: no set bit below VL
        run("R9", 8, 2, 0, 0, 0, 64'hF00, 64'h0, 64'hFF, 64'h0, 1, 1, 2, 1);
        // R14: base 64 is not register zero; base 0 scalar is
        run("R14", 2, 0, 0, 0, 0, 0, 0, 0, 0, 64, 0, 5, 1);
        run("R14", 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5, 1);

        // R11: stall in the middle of a loop
        begin
            int pd;
            req = "R11";
            setvl(4, 0, 0);
            model(4, 0, 0, 0, 0, '1, '1, 30, 1, 70, 1);
            pd = n_done;
            @(negedge clk);
            pmode = 0; zeroing = 0; src_base = 30; src_vec = 1; dst_base = 70; dst_vec = 1;
            instr_valid = 1;
            @(negedge clk);
            instr_valid = 0;
            @(negedge clk);
            stall = 1;
            for (int c = 0; c < 2; c++) begin
                #4;
                check(!iv, "R11", "issue while stalled", iv, 0);
                check(state[20:14] == 1, "R11", "step held", state[20:14], 1);
                @(negedge clk);
            end
            stall = 0;
            while (n_done == pd) @(negedge clk);
            check(exp_q.size() == 0, "R11", "elements after stall", exp_q.size(), 0);
        end

        // R12 / R13: exception mid-loop, resume from saved steps
        begin
            int pd, base;
            req = "R12";
            setvl(8, 0, 0);
            model(8, 0, 0, 0, 0, '1, '1, 12, 1, 90, 1);
            base = n_iss; pd = n_done;
            @(negedge clk);
            src_base = 12; dst_base = 90; src_vec = 1; dst_vec = 1; pmode = 0; instr_valid = 1;
            @(negedge clk);
            instr_valid = 0;
            while (n_iss < base + 3) @(negedge clk);
            exc = 1;
            #4;
            check(!iv, "R12", "issue in exception cycle", iv, 0);
            @(negedge clk);
            exc = 0;
            check(sstb == 1, "R12", "save strobe", sstb, 1);
            check(save[27:14] == {7'd3, 7'd3}, "R12", "saved steps", save[27:14], {7'd3, 7'd3});
            check(!busy, "R12", "busy after exception", busy, 0);
            setvl(2, 0, 0);
            @(negedge clk);
            restore = 1;
            @(negedge clk);
            restore = 0;
            req = "R13";
            check(state[27:7] == {7'd3, 7'd3, 7'd8}, "R13", "restored state",
                  state[27:7], {7'd3, 7'd3, 7'd8});
            instr_valid = 1;
            @(negedge clk);
            instr_valid = 0;
            while (n_done == pd) @(negedge clk);
            check(exp_q.size() == 0, "R13", "resumed elements", exp_q.size(), 0);
            check(n_iss == base + 8, "R13", "total elements", n_iss - base, 8);
        end

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule